// File: doc/BRIEF.md
# Codeword-to-Layer Mapper

This block takes the modulated symbol streams of one or two codewords and deals them onto up to eight spatial layers. Each transfer is set up with a start pulse that carries the layer count and the symbol count of each codeword. After setup, the block collects one symbol per active layer from the codeword inputs, using a valid/ready handshake on each input. When a full group is present, it presents all active layers in the same cycle.

How the layers are shared between the codewords depends on the layer count. Up to four layers, only codeword 0 is used. From five to eight layers, codeword 0 takes the lower half of the layers, rounded down, and codeword 1 takes the rest. Within a codeword, symbols go round-robin across that codeword's layers.

A start pulse with an invalid setup is refused and the error flag is raised. An invalid setup is a layer count outside 1 to 8, a length that does not split evenly, or two codewords that would give different per-layer counts.

Top module: `lmap_top`

## Requirements
- R1: The layer count L selects how many layers each codeword feeds. For L of 1 to 4, codeword 0 feeds L layers and codeword 1 feeds none. For L of 5, 6, 7 and 8, the split is 2+3, 3+3, 3+4 and 4+4. Codeword 0 always takes the lowest-numbered lanes and codeword 1 the lanes directly above them.
- R2: Within a codeword that feeds n layers, output group g on that codeword's local layer j carries codeword symbol n*g + j. With L=1, every symbol goes straight to lane 0.
- R3: All active lanes of a group are presented in one cycle. In that cycle, out_valid has a 1 on exactly lanes 0 to L-1.
- R4: A lane whose out_valid bit is low drives zero on both out_i and out_q. This includes every lane at or above L, and every lane in a cycle with no output.
- R5: While a transfer with L of 4 or fewer is running, cw1_ready stays low, and symbols offered on codeword 1 are neither taken nor output.
- R6: A start with cfg_layers of 0 or above 8 sets cfg_err and starts no transfer. The next accepted start clears cfg_err.
- R7: A start is refused and cfg_err is set when a codeword length is zero or is not a multiple of that codeword's layer count.
- R8: For L of 5 to 8, a start is refused and cfg_err is set when len0/n0 differs from len1/n1.
- R9: out_last is high together with the final group of a transfer. After that group, the block is idle and both ready outputs are low.
- R10: A start pulse during a running transfer is ignored. The transfer goes on unchanged, and cfg_err keeps its value.
- R11: A codeword that has delivered its share of the current group holds its ready low until the other codeword completes the group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_start | input | 1 | Start pulse for a transfer, sampled while idle |
| cfg_layers | input | 4 | Layer count for the transfer (valid values 1 to 8) |
| cfg_len0 | input | LEN_W | Symbol count of codeword 0 |
| cfg_len1 | input | LEN_W | Symbol count of codeword 1 (used only for 5 to 8 layers) |
| cw0_valid | input | 1 | Codeword 0 symbol valid |
| cw0_i | input | SW | Codeword 0 in-phase sample |
| cw0_q | input | SW | Codeword 0 quadrature sample |
| cw0_ready | output | 1 | Codeword 0 can accept a symbol |
| cw1_valid | input | 1 | Codeword 1 symbol valid |
| cw1_i | input | SW | Codeword 1 in-phase sample |
| cw1_q | input | SW | Codeword 1 quadrature sample |
| cw1_ready | output | 1 | Codeword 1 can accept a symbol |
| out_valid | output | 8 | Per-lane valid, all active lanes together |
| out_i | output | 8 x SW | Per-lane in-phase samples |
| out_q | output | 8 x SW | Per-lane quadrature samples |
| out_last | output | 1 | Marks the final group of a transfer |
| cfg_err | output | 1 | The last start was refused |

## Verification
The assertions assume the following about the inputs:
- cfg_layers and the lengths are only looked at in the cycle of an idle start.
- A stream keeps its symbol on the lines for the whole cycle in which it offers it.
- No input is unknown after reset.

The stimulus keeps within these assumptions:
- Every input changes only on the falling clock edge.
- Setup values are held for exactly the one start cycle.
- Lengths stay well inside the LEN_W range.
- Gaps in the valid signals are inserted on a fixed cycle pattern.

The bench also delays one codeword on purpose, to expose the stall of the other one.

// File: rtl/lmap_pkg.sv
package lmap_pkg;

    localparam int MAX_LAYERS = 8;
    localparam int CW_LAYERS  = 4;
    localparam int SHARE_W    = $clog2(CW_LAYERS + 1);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } lmap_state_e;

    // Layers fed by codeword 0: all of them up to four, else the lower half
    function automatic logic [SHARE_W-1:0] share_cw0(input logic [3:0] layers);
        if (layers <= 4'd4) return SHARE_W'(layers);
        return SHARE_W'(layers >> 1);
    endfunction

    // Layers fed by codeword 1: whatever codeword 0 leaves over
    function automatic logic [SHARE_W-1:0] share_cw1(input logic [3:0] layers);
        if (layers <= 4'd4) return '0;
        return SHARE_W'(layers - (layers >> 1));
    endfunction

endpackage

// File: rtl/lmap_cfg_check.sv
module lmap_cfg_check
    import lmap_pkg::*;
#(
    parameter int LEN_W = 12
) (
    input  logic [3:0]         layers,
    input  logic [LEN_W-1:0]   len0,
    input  logic [LEN_W-1:0]   len1,
    output logic [SHARE_W-1:0] n0,
    output logic [SHARE_W-1:0] n1,
    output logic [LEN_W-1:0]   groups,
    output logic               bad
);

    // Division by the small layer shares 1..4
    function automatic logic [LEN_W-1:0] div_share(input logic [LEN_W-1:0] v,
                                                   input logic [SHARE_W-1:0] n);
        case (n)
            SHARE_W'(1): return v;
            SHARE_W'(2): return v >> 1;
            SHARE_W'(3): return v / LEN_W'(3);
            SHARE_W'(4): return v >> 2;
            default:     return '0;
        endcase
    endfunction

    logic [LEN_W-1:0] q0, q1;
    logic             range_ok, even0, even1, match;

    always_comb begin
        n0       = share_cw0(layers);
        n1       = share_cw1(layers);
        q0       = div_share(len0, n0);
        q1       = div_share(len1, n1);
        range_ok = (layers >= 4'd1) && (layers <= 4'd8);
        even0    = (len0 != '0) && ((q0 * LEN_W'(n0)) == len0);
        even1    = (n1 == '0) || ((len1 != '0) && ((q1 * LEN_W'(n1)) == len1));
        match    = (n1 == '0) || (q1 == q0);
        bad      = !(range_ok && even0 && even1 && match);
        groups   = q0;
    end

endmodule

// File: rtl/lmap_gather.sv
module lmap_gather
    import lmap_pkg::*;
#(
    parameter int SW    = 16,
    parameter int SLOTS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       en,
    input  logic [SHARE_W-1:0]         n_slots,
    input  logic                       flush,
    input  logic                       s_valid,
    input  logic [SW-1:0]              s_i,
    input  logic [SW-1:0]              s_q,
    output logic                       s_ready,
    output logic                       grp_full,
    output logic [SLOTS-1:0][SW-1:0]   slot_i,
    output logic [SLOTS-1:0][SW-1:0]   slot_q
);

    localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1;

    typedef struct packed {
        logic [SHARE_W-1:0]         fill;
        logic [SLOTS-1:0][SW-1:0]   si;
        logic [SLOTS-1:0][SW-1:0]   sq;
    } gat_t;

    gat_t cur_q, nxt, cur_d;

    always_comb begin
        nxt     = cur_q;
        s_ready = en && (cur_q.fill < n_slots);
        if (s_ready && s_valid) begin
            nxt.si[cur_q.fill[IDX_W-1:0]] = s_i;
            nxt.sq[cur_q.fill[IDX_W-1:0]] = s_q;
            nxt.fill = cur_q.fill + SHARE_W'(1);
        end
        grp_full = en && (nxt.fill == n_slots);
        slot_i   = nxt.si;
        slot_q   = nxt.sq;
        cur_d    = nxt;
        if (flush || !en) begin
            cur_d.fill = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

endmodule

// File: rtl/lmap_top.sv
module lmap_top
    import lmap_pkg::*;
#(
    parameter int SW    = 16,
    parameter int LEN_W = 12
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cfg_start,
    input  logic [3:0]                          cfg_layers,
    input  logic [LEN_W-1:0]                    cfg_len0,
    input  logic [LEN_W-1:0]                    cfg_len1,
    input  logic                                cw0_valid,
    input  logic [SW-1:0]                       cw0_i,
    input  logic [SW-1:0]                       cw0_q,
    output logic                                cw0_ready,
    input  logic                                cw1_valid,
    input  logic [SW-1:0]                       cw1_i,
    input  logic [SW-1:0]                       cw1_q,
    output logic                                cw1_ready,
    output logic [MAX_LAYERS-1:0]               out_valid,
    output logic [MAX_LAYERS-1:0][SW-1:0]       out_i,
    output logic [MAX_LAYERS-1:0][SW-1:0]       out_q,
    output logic                                out_last,
    output logic                                cfg_err
);

    localparam int NL     = MAX_LAYERS;
    localparam int LANE_W = $clog2(NL);
    localparam int NCW    = 2;

    typedef struct packed {
        lmap_state_e                st;
        logic [SHARE_W-1:0]         n0;
        logic [SHARE_W-1:0]         n1;
        logic [LEN_W-1:0]           left;
        logic [NL-1:0]              vld;
        logic [NL-1:0][SW-1:0]      li;
        logic [NL-1:0][SW-1:0]      lq;
        logic                       last;
        logic                       err;
    } state_t;

    state_t cur_q, cur_d;

    // Setup check
    logic [SHARE_W-1:0] chk_n0, chk_n1;
    logic [LEN_W-1:0]   chk_groups;
    logic               chk_bad;

    lmap_cfg_check #(.LEN_W(LEN_W)) u_check (
        .layers (cfg_layers),
        .len0   (cfg_len0),
        .len1   (cfg_len1),
        .n0     (chk_n0),
        .n1     (chk_n1),
        .groups (chk_groups),
        .bad    (chk_bad)
    );

    // Per-codeword group collectors
    logic                          run_w;
    logic                          emit;
    logic                          cw_vld   [NCW];
    logic [SW-1:0]                 cw_si    [NCW];
    logic [SW-1:0]                 cw_sq    [NCW];
    logic                          cw_rdy   [NCW];
    logic                          cw_full  [NCW];
    logic [CW_LAYERS-1:0][SW-1:0]  slot_i   [NCW];
    logic [CW_LAYERS-1:0][SW-1:0]  slot_q   [NCW];
    logic [SHARE_W-1:0]            n1_w;

    assign run_w     = (cur_q.st == ST_RUN);
    assign n1_w      = cur_q.n1;
    assign cw_vld[0] = cw0_valid;
    assign cw_si[0]  = cw0_i;
    assign cw_sq[0]  = cw0_q;
    assign cw_vld[1] = cw1_valid;
    assign cw_si[1]  = cw1_i;
    assign cw_sq[1]  = cw1_q;
    assign cw0_ready = cw_rdy[0];
    assign cw1_ready = cw_rdy[1];

    for (genvar c = 0; c < NCW; c++) begin : g_cw
        lmap_gather #(.SW(SW), .SLOTS(CW_LAYERS)) u_gather (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (run_w),
            .n_slots  ((c == 0) ? cur_q.n0 : cur_q.n1),
            .flush    (emit),
            .s_valid  (cw_vld[c]),
            .s_i      (cw_si[c]),
            .s_q      (cw_sq[c]),
            .s_ready  (cw_rdy[c]),
            .grp_full (cw_full[c]),
            .slot_i   (slot_i[c]),
            .slot_q   (slot_q[c])
        );
    end

    assign emit = run_w && cw_full[0] && cw_full[1];

    always_comb begin
        logic [LANE_W-1:0] lane;
        cur_d      = cur_q;
        cur_d.vld  = '0;
        cur_d.li   = '0;
        cur_d.lq   = '0;
        cur_d.last = 1'b0;
        lane       = '0;
        case (cur_q.st)
            ST_IDLE: begin
                if (cfg_start) begin
                    if (chk_bad) begin
                        cur_d.err = 1'b1;
                    end else begin
                        cur_d.err  = 1'b0;
                        cur_d.n0   = chk_n0;
                        cur_d.n1   = chk_n1;
                        cur_d.left = chk_groups;
                        cur_d.st   = ST_RUN;
                    end
                end
            end
            ST_RUN: begin
                if (emit) begin
                    for (int k = 0; k < CW_LAYERS; k++) begin
                        if (SHARE_W'(k) < cur_q.n0) begin
                            cur_d.vld[k] = 1'b1;
                            cur_d.li[k]  = slot_i[0][k];
                            cur_d.lq[k]  = slot_q[0][k];
                        end
                    end
                    for (int k = 0; k < CW_LAYERS; k++) begin
                        lane = LANE_W'(cur_q.n0) + LANE_W'(k);
                        if (SHARE_W'(k) < cur_q.n1) begin
                            cur_d.vld[lane] = 1'b1;
                            cur_d.li[lane]  = slot_i[1][k];
                            cur_d.lq[lane]  = slot_q[1][k];
                        end
                    end
                    cur_d.left = cur_q.left - LEN_W'(1);
                    if (cur_q.left == LEN_W'(1)) begin
                        cur_d.last = 1'b1;
                        cur_d.st   = ST_IDLE;
                    end
                end
            end
            default: cur_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    assign out_valid = cur_q.vld;
    assign out_i     = cur_q.li;
    assign out_q     = cur_q.lq;
    assign out_last  = cur_q.last;
    assign cfg_err   = cur_q.err;

endmodule

// File: rtl/lmap_chk.sv
module lmap_chk #(
    parameter int NL      = 8,
    parameter int SW      = 16,
    parameter int SHARE_W = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   cfg_start,
    input logic [3:0]             cfg_layers,
    input logic                   run,
    input logic [SHARE_W-1:0]     n1,
    input logic                   cw0_ready,
    input logic                   cw1_ready,
    input logic [NL-1:0]          out_valid,
    input logic [NL-1:0][SW-1:0]  out_i,
    input logic [NL-1:0][SW-1:0]  out_q,
    input logic                   out_last,
    input logic                   cfg_err
);

    assert_lanes_from_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (NL'(out_valid + NL'(1)) & out_valid) == '0);

    for (genvar k = 0; k < NL; k++) begin : g_lane
        assert_quiet_lane_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid[k] |-> (out_i[k] == '0 && out_q[k] == '0));
    end

    assert_cw1_unused_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && n1 == '0) |-> !cw1_ready);

    assert_bad_layers_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && cfg_start && (cfg_layers == 4'd0 || cfg_layers > 4'd8)) |=> (cfg_err && !run));

    assert_last_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> ((|out_valid) && !run));

    assert_idle_no_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!cw0_ready && !cw1_ready));

    assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cfg_start) |=> $stable(cfg_err));

endmodule

bind lmap_top lmap_chk #(
    .NL      (lmap_pkg::MAX_LAYERS),
    .SW      (SW),
    .SHARE_W (lmap_pkg::SHARE_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_start  (cfg_start),
    .cfg_layers (cfg_layers),
    .run        (run_w),
    .n1         (n1_w),
    .cw0_ready  (cw0_ready),
    .cw1_ready  (cw1_ready),
    .out_valid  (out_valid),
    .out_i      (out_i),
    .out_q      (out_q),
    .out_last   (out_last),
    .cfg_err    (cfg_err)
);

// File: tb/sim_lmap_top.sv
module sim_lmap_top;

    localparam int SW    = 16;
    localparam int LEN_W = 12;
    localparam int NL    = 8;

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      cfg_start = 1'b0;
    logic [3:0]                cfg_layers = '0;
    logic [LEN_W-1:0]          cfg_len0 = '0;
    logic [LEN_W-1:0]          cfg_len1 = '0;
    logic                      cw0_valid = 1'b0;
    logic [SW-1:0]             cw0_i = '0;
    logic [SW-1:0]             cw0_q = '0;
    logic                      cw0_ready;
    logic                      cw1_valid = 1'b0;
    logic [SW-1:0]             cw1_i = '0;
    logic [SW-1:0]             cw1_q = '0;
    logic                      cw1_ready;
    logic [NL-1:0]             out_valid;
    logic [NL-1:0][SW-1:0]     out_i;
    logic [NL-1:0][SW-1:0]     out_q;
    logic                      out_last;
    logic                      cfg_err;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    lmap_top #(.SW(SW), .LEN_W(LEN_W)) u0 (.*);

    typedef struct packed {
        logic                  last;
        logic [NL-1:0]         v;
        logic [NL-1:0][SW-1:0] i;
        logic [NL-1:0][SW-1:0] q;
    } exp_t;

    exp_t sbq[$];

    function automatic logic [SW-1:0] sym_i(input int c, input int k);
        return {(c == 0) ? 4'h1 : 4'h8, 12'(k)};
    endfunction

    function automatic logic [SW-1:0] sym_q(input int c, input int k);
        return sym_i(c, k) ^ 16'h5A3C;
    endfunction

    // R1 split table
    function automatic int share0(input int L);
        return (L <= 4) ? L : L / 2;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Driver side of the scoreboard: R1/R2 expected groups
    task automatic push_expected(input int L, input int len0);
        int n0, n1, grp;
        exp_t e;
        n0  = share0(L);
        n1  = L - n0;
        grp = len0 / n0;
        for (int g = 0; g < grp; g++) begin
            e = '0;
            e.last = (g == grp - 1);
            for (int l = 0; l < n0; l++) begin
                e.v[l] = 1'b1;
                e.i[l] = sym_i(0, n0 * g + l);
                e.q[l] = sym_q(0, n0 * g + l);
            end
            for (int l = 0; l < n1; l++) begin
                e.v[n0 + l] = 1'b1;
                e.i[n0 + l] = sym_i(1, n1 * g + l);
                e.q[n0 + l] = sym_q(1, n1 * g + l);
            end
            sbq.push_back(e);
        end
    endtask

    // Monitor: compares every output group (R2, R3, R4, R9)
    always @(negedge clk) begin
        exp_t got, want;
        if (rst_n && (|out_valid)) begin
            got = {out_last, out_valid, out_i, out_q};
            if (sbq.size() == 0) begin
                check(1'b0, "R3 unexpected group", 64'(out_valid), 64'h0);
            end else begin
                want = sbq.pop_front();
                n_tests++;
                if (got != want) begin
                    n_fail++;
                    $display("FAIL R2/R3/R4/R9 group actual=%h expected=%h", got, want);
                end
            end
        end
    end

    task automatic do_start(input int L, input int l0, input int l1);
        @(negedge clk);
        cfg_start  = 1'b1;
        cfg_layers = 4'(L);
        cfg_len0   = LEN_W'(l0);
        cfg_len1   = LEN_W'(l1);
        @(negedge clk);
        cfg_start  = 1'b0;
    endtask

    task automatic feed0(input int len, input int gap);
        int cnt = 0;
        int t = 0;
        while (cnt < len) begin
            @(negedge clk);
            t++;
            cw0_valid = (gap == 0) || ((t % gap) != 0);
            cw0_i = sym_i(0, cnt);
            cw0_q = sym_q(0, cnt);
            if (cw0_valid && cw0_ready) cnt++;
        end
        @(negedge clk);
        cw0_valid = 1'b0;
    endtask

    task automatic feed1(input int len, input int gap, input int delay);
        int cnt = 0;
        int t = 0;
        repeat (delay) @(negedge clk);
        while (cnt < len) begin
            @(negedge clk);
            t++;
            cw1_valid = (gap == 0) || ((t % gap) != 0);
            cw1_i = sym_i(1, cnt);
            cw1_q = sym_q(1, cnt);
            if (cw1_valid && cw1_ready) cnt++;
        end
        @(negedge clk);
        cw1_valid = 1'b0;
    endtask

    task automatic drain();
        while (sbq.size() != 0) @(negedge clk);
        @(negedge clk);
        check(!cw0_ready && !cw1_ready, "R9 idle after last", {cw0_ready, cw1_ready}, 0);
    endtask

    task automatic xfer(input int L, input int l0, input int l1, input int g0, input int g1);
        push_expected(L, l0);
        do_start(L, l0, l1);
        fork
            feed0(l0, g0);
            if (L > 4) feed1(l1, g1, 0);
        join
        drain();
    endtask

    task automatic bad_start(input int L, input int l0, input int l1, input string req);
        do_start(L, l0, l1);
        check(cfg_err && !cw0_ready, req, {cfg_err, cw0_ready}, 2'b10);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == '0 && !cfg_err && !cw0_ready && !out_last, "R4 reset state",
              {out_valid, cfg_err, cw0_ready}, 0);

        // R1 R2: single layer pass-through and one-codeword splits
        xfer(1, 5, 0, 0, 0);
        xfer(2, 8, 0, 3, 0);

        // R5: codeword 1 offered but never taken for 3 layers
        cw1_valid = 1'b1;
        cw1_i = 16'hDEAD;
        cw1_q = 16'hBEEF;
        push_expected(3, 9);
        do_start(3, 9, 0);
        fork
            feed0(9, 0);
            begin
                repeat (3) @(negedge clk);
                check(!cw1_ready, "R5 cw1 ready low", cw1_ready, 0);
            end
        join
        drain();
        cw1_valid = 1'b0;

        xfer(4, 12, 0, 0, 0);
        // R1 R2: two-codeword splits
        xfer(5, 6, 9, 0, 4);
        xfer(6, 12, 12, 3, 2);
        xfer(7, 9, 12, 0, 0);
        xfer(8, 8, 8, 2, 0);

        // R11: codeword 0 stalls while codeword 1 is late
        push_expected(8, 4);
        do_start(8, 4, 4);
        fork
            feed0(4, 0);
            feed1(4, 0, 8);
            begin
                repeat (6) @(negedge clk);
                check(!cw0_ready && out_valid == '0, "R11 cw0 waits for cw1",
                      {cw0_ready, out_valid}, 0);
            end
        join
        drain();

        // R6 R7 R8: refused setups
        bad_start(0, 4, 0, "R6 zero layers");
        bad_start(9, 9, 9, "R6 nine layers");
        bad_start(3, 10, 0, "R7 len0 not multiple");
        bad_start(2, 0, 0, "R7 zero length");
        bad_start(5, 6, 10, "R7 len1 not multiple");
        bad_start(6, 9, 12, "R8 per-layer mismatch");

        // R6: a good start clears the flag
        push_expected(2, 4);
        do_start(2, 4, 0);
        check(!cfg_err, "R6 error cleared", cfg_err, 0);
        feed0(4, 0);
        drain();

        // R10: start during a running transfer has no effect
        push_expected(4, 8);
        do_start(4, 8, 0);
        fork
            feed0(8, 2);
            begin
                repeat (2) @(negedge clk);
                cfg_start  = 1'b1;
                cfg_layers = 4'd0;
                @(negedge clk);
                cfg_start  = 1'b0;
                check(!cfg_err, "R10 busy start ignored", cfg_err, 0);
            end
        join
        drain();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule